// File: doc/BRIEF.md
# Vectored Nested Interrupt Collector

This block gathers level-sensitive interrupt requests from a parameterised set of peripheral sources. Each source has a configuration nibble: a 2-bit priority, an enable bit and a software-force bit. Among the sources that are enabled and pending, the block picks a winner and raises a single IRQ line towards the processor. A vector register returns a programmable base address plus four times the index of the winning source, so software can jump straight into a table of handlers.

Nesting is tracked in hardware. In claim-on-read mode, reading the vector register claims the winner and marks its priority level as in service. From then on only sources with a strictly higher priority than every in-service level can raise the IRQ. Software ends a handler by writing a one-hot word to the level-retire register, which clears the named in-service levels.

A small controller with two states drives the IRQ pin. `ST_IDLE` keeps the pin low. The transition *raise* moves to `ST_SIGNAL` when an eligible source exists and the global enable is set. `ST_SIGNAL` drives the pin high. The transition *drop* returns to `ST_IDLE` when no eligible source remains, when the global enable is clear, when a claim occurs or when a level is retired. The register port is a plain 32-bit word-addressed strobe interface. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, every source has priority 0 and is disabled with no force request, the control word and vector base read 0, no level is in service, and `irq_o` is low.
- R2: Source s is configured through word address 4 + s/4, in byte s%4 of that word. Bits [1:0] of the byte hold the priority, bit 2 the enable and bit 3 the force request. Bits [7:4] of each byte read back as 0.
- R3: A vector read (word address 1) returns base + 4 × index of the winner. The winner is the enabled pending eligible source with the highest priority, with the lowest index winning among equal priorities. A disabled source never wins.
- R4: Setting a source's force bit makes it pending even though its line is low. Clearing the force bit withdraws that request.
- R5: `irq_o` rises one cycle after an eligible source appears, provided the global enable (control bit 1) is set. It falls when no eligible source remains or when the global enable is cleared.
- R6: When claim-on-read mode (control bit 0) is set, a vector read that finds a winner marks the winner's priority level in service. With that bit clear, a vector read changes no nesting state and `irq_o` stays high.
- R7: A source is eligible only when its priority is strictly greater than every in-service level.
- R8: A write to word address 2 retires in-service level n for each bit n in [3:0] that is 1. The IRQ is re-evaluated, and `irq_o` can rise again in the cycle after the next clock edge.
- R9: A vector read made while no source is eligible returns the base address unchanged and leaves the in-service levels untouched.
- R10: `irq_o` is low for at least the cycle that follows a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| src_line_i | input | N_SRC | Level request lines, one per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle, so a claim and a level retirement cannot collide. They also assume that the source lines are already synchronous to the clock. The stimulus issues exactly one register operation per transaction and drives every input on the falling edge, which keeps both conditions true. Claim, retirement and vector-read cases are each reached through the normal register port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int PRIO_W = 2;
    localparam int NLVL   = 4;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_VECT  = 1;
    localparam int ADR_LACK  = 2;
    localparam int ADR_VBASE = 3;
    localparam int ADR_SRC0  = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    // per-source configuration nibble
    typedef struct packed {
        logic  force_req;
        logic  enable;
        prio_t prio;
    } src_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SIGNAL = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int NREG  = N_SRC / 4,
    parameter int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_wr_i,
    input  logic [SEL_W-1:0]     cfg_sel_i,
    input  src_cfg_t [3:0]       cfg_wdata_i,
    input  logic [N_SRC-1:0]     line_i,
    output src_cfg_t [N_SRC-1:0] cfg_o,
    output logic [N_SRC-1:0]     req_o,
    output prio_t [N_SRC-1:0]    prio_o
);
    src_cfg_t [N_SRC-1:0] cfg_q;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        localparam int REG  = s / 4;
        localparam int LANE = s % 4;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cfg_q[s] <= '0;
            end else if (cfg_wr_i && (cfg_sel_i == SEL_W'(REG))) begin
                cfg_q[s] <= cfg_wdata_i[LANE];
            end
        end

        // forced requests count as pending even with a quiet line
        assign req_o[s]  = cfg_q[s].enable & (line_i[s] | cfg_q[s].force_req);
        assign prio_o[s] = cfg_q[s].prio;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/irqc_level_track.sv
module irqc_level_track
    import irqc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            claim_i,
    input  prio_t           claim_lvl_i,
    input  logic            retire_i,
    input  logic [NLVL-1:0] retire_mask_i,
    output logic [NLVL-1:0] isv_o,
    output logic            busy_o,
    output prio_t           top_lvl_o
);
    logic [NLVL-1:0] isv_q;
    logic [NLVL-1:0] set_mask;
    logic [NLVL-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        if (claim_i) set_mask[claim_lvl_i] = 1'b1;
        clr_mask = retire_i ? retire_mask_i : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) isv_q <= '0;
        else         isv_q <= (isv_q & ~clr_mask) | set_mask;
    end

    // highest in-service level
    always_comb begin
        top_lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (isv_q[l]) top_lvl_o = prio_t'(l);
        end
    end

    assign busy_o = |isv_q;
    assign isv_o  = isv_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  req_i,
    input  prio_t [N_SRC-1:0] prio_i,
    input  logic              busy_i,
    input  prio_t             top_lvl_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output prio_t             win_prio_o
);
    logic [N_SRC-1:0] elig;

    for (genvar s = 0; s < N_SRC; s++) begin : g_elig
        assign elig[s] = req_i[s] & (!busy_i || (prio_i[s] > top_lvl_i));
    end

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        any_o      = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (elig[s] && (!any_o || (prio_i[s] > win_prio_o))) begin
                any_o      = 1'b1;
                win_idx_o  = IDX_W'(s);
                win_prio_o = prio_i[s];
            end
        end
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [N_SRC-1:0]  src_line_i,
    output logic              irq_o
);
    localparam int NREG  = N_SRC / 4;
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    // register decode
    logic hit_ctrl, hit_vect, hit_lack, hit_vbase, hit_src;
    logic [SEL_W-1:0] src_sel;

    always_comb begin
        hit_ctrl  = (reg_addr_i == ADDR_W'(ADR_CTRL));
        hit_vect  = (reg_addr_i == ADDR_W'(ADR_VECT));
        hit_lack  = (reg_addr_i == ADDR_W'(ADR_LACK));
        hit_vbase = (reg_addr_i == ADDR_W'(ADR_VBASE));
        hit_src   = (reg_addr_i >= ADDR_W'(ADR_SRC0)) &&
                    (reg_addr_i <  ADDR_W'(ADR_SRC0 + NREG));
        src_sel   = SEL_W'(reg_addr_i - ADDR_W'(ADR_SRC0));
    end

    // control and base registers
    logic        rse_q;
    logic        final_q;
    logic [31:0] vbase_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rse_q   <= 1'b0;
            final_q <= 1'b0;
            vbase_q <= '0;
        end else if (reg_wr_i) begin
            if (hit_ctrl) begin
                rse_q   <= reg_wdata_i[0];
                final_q <= reg_wdata_i[1];
            end
            if (hit_vbase) vbase_q <= reg_wdata_i;
        end
    end

    // source bank
    src_cfg_t [3:0]       cfg_wdata;
    src_cfg_t [N_SRC-1:0] cfg;
    logic [N_SRC-1:0]     req;
    prio_t [N_SRC-1:0]    prio;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign cfg_wdata[b] = src_cfg_t'(reg_wdata_i[8*b +: 4]);
    end

    irqc_src_bank #(.N_SRC(N_SRC), .NREG(NREG), .SEL_W(SEL_W)) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_wr_i    (reg_wr_i && hit_src),
        .cfg_sel_i   (src_sel),
        .cfg_wdata_i (cfg_wdata),
        .line_i      (src_line_i),
        .cfg_o       (cfg),
        .req_o       (req),
        .prio_o      (prio)
    );

    // nesting state
    logic             claim;
    logic             retire;
    logic [NLVL-1:0]  isv;
    logic             busy;
    prio_t            top_lvl;
    logic             any_elig;
    logic [IDX_W-1:0] win_idx;
    prio_t            win_prio;

    assign claim  = reg_rd_i && hit_vect && rse_q && any_elig;
    assign retire = reg_wr_i && hit_lack;

    irqc_level_track u_lvl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .claim_i       (claim),
        .claim_lvl_i   (win_prio),
        .retire_i      (retire),
        .retire_mask_i (reg_wdata_i[NLVL-1:0]),
        .isv_o         (isv),
        .busy_o        (busy),
        .top_lvl_o     (top_lvl)
    );

    irqc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .req_i      (req),
        .prio_i     (prio),
        .busy_i     (busy),
        .top_lvl_i  (top_lvl),
        .any_o      (any_elig),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    // read path
    logic [NREG-1:0][31:0] src_words;
    logic [31:0]           vec_value;
    logic [31:0]           rd_mux;
    logic [31:0]           rdata_q;

    for (genvar r = 0; r < NREG; r++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            assign src_words[r][8*b +: 8] = {4'b0000, cfg[4*r + b]};
        end
    end

    assign vec_value = any_elig ? (vbase_q + 32'({win_idx, 2'b00})) : vbase_q;

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)  rd_mux = {30'd0, final_q, rse_q};
        if (hit_vect)  rd_mux = vec_value;
        if (hit_vbase) rd_mux = vbase_q;
        if (hit_src)   rd_mux = src_words[src_sel];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       rdata_q <= '0;
        else if (reg_rd_i) rdata_q <= rd_mux;
    end

    assign reg_rdata_o = rdata_q;

    // IRQ controller
    irq_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_elig && final_q && !claim && !retire) state_d = ST_SIGNAL;
            ST_SIGNAL: if (!any_elig || !final_q || claim || retire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_SIGNAL);
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic            irq_o,
    input logic            final_q,
    input logic            claim,
    input prio_t           win_prio,
    input logic            any_elig,
    input logic [NLVL-1:0] isv,
    input logic            retire,
    input logic [NLVL-1:0] retire_mask,
    input logic            vec_rd
);
    // R5: the pin is high only if the global enable was set one cycle before
    assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(final_q));

    // R6: a claim marks the claimed level in service
    assert_claim_marks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim |=> isv[$past(win_prio)]);

    // R7: a claim never lands on or below an in-service level
    assert_claim_above_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim |-> ((isv >> win_prio) == '0));

    // R8: retired levels are clear after the write
    assert_retire_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire && !claim) |=> ((isv & $past(retire_mask)) == '0));

    // R9: a vector read with nothing eligible leaves nesting state alone
    assert_idle_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_rd && !any_elig && !retire) |=> $stable(isv));

    // R10: the pin is low right after a claim
    assert_claim_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim |=> !irq_o);
endmodule

bind irq_nest_ctrl irqc_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_o       (irq_o),
    .final_q     (final_q),
    .claim       (claim),
    .win_prio    (win_prio),
    .any_elig    (any_elig),
    .isv         (isv),
    .retire      (retire),
    .retire_mask (reg_wdata_i[3:0]),
    .vec_rd      (reg_rd_i && hit_vect)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
    localparam int N_SRC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N_SRC-1:0] lines = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #2 clk = ~clk;

    irq_nest_ctrl #(.N_SRC(N_SRC), .ADDR_W(4)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .src_line_i  (lines),
        .irq_o       (irq)
    );

    // monitor: pops expected read data and compares
    always @(posedge clk) rd_q <= reg_rd;

    always @(negedge clk) begin
        if (rd_q) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (reg_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(4'd0, 32'h0, "R1 ctrl");
        rd(4'd4, 32'h0, "R1 src word0");
        rd(4'd5, 32'h0, "R1 src word1");
        rd(4'd3, 32'h0, "R1 vbase");
        rd(4'd1, 32'h0, "R9 vector at reset");

        // R2 layout: src0 p1 en, src1 p2 en, src2 p2 en, src3 p3 disabled
        wr(4'd3, 32'h0000_1000);
        rd(4'd3, 32'h0000_1000, "R3 vbase readback");
        wr(4'd4, 32'hF3F6_F6F5);
        rd(4'd4, 32'h0306_0605, "R2 packed bytes, upper nibbles zero");

        // R5 global enable, no lines
        wr(4'd0, 32'h2);
        rd(4'd0, 32'h2, "R5 ctrl readback");
        idle(1);
        chk_irq(1'b0, "R5 no pending source");
        lines = 8'h0F;
        @(negedge clk);
        chk_irq(1'b1, "R5 raise one cycle after eligible");

        // R3 winner, R6 no claim without claim-on-read
        rd(4'd1, 32'h0000_1004, "R3 highest prio lowest index, disabled ignored");
        idle(1);
        chk_irq(1'b1, "R6 no claim with claim-on-read off");

        // R6 claim, R10 drop, R7 nesting
        wr(4'd0, 32'h3);
        chk_irq(1'b1, "R5 still high");
        rd(4'd1, 32'h0000_1004, "R6 claim read");
        chk_irq(1'b0, "R10 low after claim");
        idle(2);
        chk_irq(1'b0, "R7 equal or lower prio blocked");
        rd(4'd1, 32'h0000_1000, "R9 vector with nothing eligible");
        idle(2);
        chk_irq(1'b0, "R9 state unchanged");

        // R4 forced source 7 at prio 3
        wr(4'd5, 32'h0F00_0000);
        chk_irq(1'b0, "R4 not yet");
        @(negedge clk);
        chk_irq(1'b1, "R4 R7 forced higher prio nests");
        rd(4'd1, 32'h0000_101C, "R3 R4 forced vector");
        chk_irq(1'b0, "R10 low after nested claim");

        // R4 withdraw, R8 retire level 3 only
        wr(4'd5, 32'h0700_0000);
        rd(4'd5, 32'h0700_0000, "R2 word1 readback");
        wr(4'd2, 32'h8);
        idle(2);
        chk_irq(1'b0, "R4 R8 withdrawn, level 2 still held");

        // R8 retire level 2
        wr(4'd2, 32'h4);
        chk_irq(1'b0, "R8 before re-evaluation");
        @(negedge clk);
        chk_irq(1'b1, "R8 re-raised after retire");
        rd(4'd1, 32'h0000_1004, "R6 reclaim level 2");
        wr(4'd2, 32'h4);
        @(negedge clk);
        chk_irq(1'b1, "R8 second retire");

        // R3 tie: drop src1, src2 wins
        wr(4'd0, 32'h2);
        lines = 8'h0D;
        rd(4'd1, 32'h0000_1008, "R3 remaining prio2 source");
        idle(1);
        chk_irq(1'b1, "R6 no claim in plain mode");

        // R5 global enable off
        wr(4'd0, 32'h0);
        idle(1);
        chk_irq(1'b0, "R5 dropped with global enable off");
        rd(4'd0, 32'h0, "R5 ctrl cleared");

        idle(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule